// File: doc/BRIEF.md
# Sticky Threshold Alert Monitor

This block watches the stream of processed temperature results coming from up to four CPU sockets, each of which reports two thermal domains, giving eight result registers. Register `i` belongs to socket `i / 2`. Every socket has its own signed 16-bit alarm threshold, which both of its domains share. A result that is not an error code and that lies strictly above its socket's threshold raises an active-low alert. The alert stays raised until a clear command arrives. The block also keeps the register index of the first result that caused the alert. A mask input stops new alerts from being raised but does not release an alert that is already raised.

The block keeps the latest result of each register. On request, a scan engine walks the enabled registers and reports the largest signed value that is not an error code. It also remembers which register held that value, so a later index read can return it. A command decoder outside this block presents 8-bit command codes through `cmd_valid`/`cmd_code`. Single-cycle reads return on `rsp_valid`/`rsp_data`. The maximum result returns on `max_valid`/`max_data`.

The alert controller has two states. In `AL_IDLE`, an unmasked violation moves it to `AL_ACTIVE` and captures the source index. In `AL_ACTIVE`, a clear with no violation in the same cycle returns it to `AL_IDLE`. A clear with a violation in the same cycle keeps it in `AL_ACTIVE` and captures the new index. Without a clear it holds. The scan engine has three states. `MX_IDLE` moves to `MX_SCAN` on a maximum-read command. `MX_SCAN` steps one register per cycle and moves to `MX_DONE` after the last register. `MX_DONE` presents the result for one cycle and returns to `MX_IDLE`. A maximum-read command that arrives during a scan is dropped.

Top module: `thermal_alert_monitor`

## Requirements
- R1: There are four thresholds, one per socket. Each resets to 7FFFh. A write with `thr_we` high stores `thr_wdata` into socket `thr_sel`, and `thr_rdata` always shows the threshold of socket `thr_sel`.
- R2: A result whose value is signed and strictly greater than the threshold of socket `res_index[2:1]` drives `alert_n` low from the cycle after it is presented. A value equal to the threshold does not.
- R3: Once `alert_n` is low, later results below the threshold do not release it.
- R4: Command 15h releases the alert in the cycle after it is presented. If an unmasked violating result is presented in the same cycle as the clear, `alert_n` stays low and the source becomes that result's index.
- R5: While `alert_mask` is high, no new alert is raised, but an alert that is already raised stays until it is cleared.
- R6: Command 0Bh answers in the next cycle with `rsp_valid` high. The data is 00h in the high byte and the index of the first violation in the low byte. Later violations do not replace that index.
- R7: Command 0Bh with no active alert answers 8103h.
- R8: A result from 8000h to 81FFh never raises an alert, whatever the threshold.
- R9: Command 08h starts a scan. It ends with a single-cycle `max_valid` pulse whose data is the largest signed value among registers that are enabled in `poll_en`, have received a result, and hold no error code. When two registers tie, the lower index wins.
- R10: If no register qualifies, the scan returns 8104h.
- R11: Command 0Ah answers 8104h before any scan has completed, or when the last scan found nothing. Otherwise it answers 00h in the high byte and the index of the last maximum in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result strobe |
| res_index | input | 3 | Register index of the result (socket*2 + domain) |
| res_value | input | 16 | Processed result value |
| poll_en | input | 8 | Per-register enable for the maximum scan |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Socket selected for threshold write and read |
| thr_wdata | input | 16 | Threshold write data |
| thr_rdata | output | 16 | Threshold of the selected socket |
| alert_mask | input | 1 | Blocks new alerts while high |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (08h, 0Ah, 0Bh, 15h) |
| rsp_valid | output | 1 | Response strobe for 0Bh and 0Ah |
| rsp_data | output | 16 | Response word |
| max_valid | output | 1 | Scan result strobe |
| max_data | output | 16 | Maximum value or error code |
| alert_n | output | 1 | Alert, low when active |

## Verification
The clear command and a new violating result can reach the alert controller in the same cycle. The required outcome is that the alert stays asserted and the stored source switches to the new index. The bench first raises an alert from one register. It then drives command 15h and a violating result for another register on the same edge, and reads the source back to check that it holds the new index. It repeats the same-cycle clear with a result that does not violate, and checks that the alert is released. A source read in the same cycle as a clear is judged against the state before the clear.

// File: rtl/tam_pkg.sv
package tam_pkg;
    localparam int DW = 16;
    typedef logic [DW-1:0] word_t;

    localparam logic [7:0] CMD_RD_MAX    = 8'h08;
    localparam logic [7:0] CMD_RD_MAXIDX = 8'h0A;
    localparam logic [7:0] CMD_RD_ASRC   = 8'h0B;
    localparam logic [7:0] CMD_CLR       = 8'h15;

    localparam word_t ERR_NO_ALERT = 16'h8103;
    localparam word_t ERR_NO_DATA  = 16'h8104;
    localparam word_t THR_RESET    = 16'h7FFF;

    typedef enum logic {AL_IDLE, AL_ACTIVE} al_state_e;
    typedef enum logic [1:0] {MX_IDLE, MX_SCAN, MX_DONE} mx_state_e;

    // error codes occupy 8000h..81FFh
    function automatic logic is_err_code(word_t v);
        return v[15:9] == 7'b1000000;
    endfunction
endpackage

// File: rtl/tam_thr_bank.sv
module tam_thr_bank
    import tam_pkg::*;
#(
    parameter int NSOCK = 4,
    parameter int NDOM  = 2,
    parameter int IW    = 3,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] sel,
    input  word_t         wr_data,
    output word_t         rd_data,
    input  logic          res_valid,
    input  logic [IW-1:0] res_index,
    input  word_t         res_value,
    output logic          over
);
    word_t         thr [NSOCK];
    logic [SW-1:0] sock;

    for (genvar g = 0; g < NSOCK; g++) begin : g_thr
        word_t r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= THR_RESET;
            else if (wr_en && sel == SW'(g))
                r <= wr_data;
        end
        assign thr[g] = r;
    end

    assign rd_data = thr[sel];
    assign sock    = SW'(res_index / IW'(NDOM));
    assign over    = res_valid && !is_err_code(res_value)
                     && ($signed(res_value) > $signed(thr[sock]));

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (thr[$past(sel)] == $past(wr_data)));
endmodule

// File: rtl/tam_alert_fsm.sv
module tam_alert_fsm
    import tam_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          over,
    input  logic [IW-1:0] idx,
    input  logic          mask,
    input  logic          clr,
    output logic          active,
    output logic [IW-1:0] src
);
    al_state_e state, nstate;
    logic      hit, capture;

    assign hit = over && !mask;

    always_comb begin
        nstate  = state;
        capture = 1'b0;
        unique case (state)
            AL_IDLE: begin
                if (hit) begin
                    nstate  = AL_ACTIVE;
                    capture = 1'b1;
                end
            end
            AL_ACTIVE: begin
                if (clr) begin
                    if (hit) capture = 1'b1;
                    else     nstate  = AL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AL_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       src <= '0;
        else if (capture) src <= idx;
    end

    assign active = (state == AL_ACTIVE);

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr) |=> active);
    a_r6_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr) |=> $stable(src));
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && mask) |=> !active);
    a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (active && clr && !over) |=> !active);
endmodule

// File: rtl/tam_max_scan.sv
module tam_max_scan
    import tam_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            res_valid,
    input  logic [IW-1:0]   res_index,
    input  word_t           res_value,
    input  logic [NREG-1:0] en,
    input  logic            start,
    output logic            rsp_valid,
    output word_t           rsp_data,
    output logic            idx_valid,
    output logic [IW-1:0]   idx
);
    logic [NREG-1:0][DW-1:0] vals;
    logic [NREG-1:0]         seen;

    for (genvar g = 0; g < NREG; g++) begin : g_store
        word_t v;
        logic  s;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v <= '0;
                s <= 1'b0;
            end else if (res_valid && res_index == IW'(g)) begin
                v <= res_value;
                s <= 1'b1;
            end
        end
        assign vals[g] = v;
        assign seen[g] = s;
    end

    mx_state_e     state, nstate;
    logic [IW-1:0] cnt;
    word_t         best;
    logic [IW-1:0] best_idx;
    logic          found;
    word_t         cand;
    logic          cand_ok, take, last;

    assign cand    = vals[cnt];
    assign cand_ok = en[cnt] && seen[cnt] && !is_err_code(cand);
    assign take    = cand_ok && (!found || ($signed(cand) > $signed(best)));
    assign last    = (cnt == IW'(NREG - 1));

    always_comb begin
        nstate = state;
        unique case (state)
            MX_IDLE: if (start) nstate = MX_SCAN;
            MX_SCAN: if (last)  nstate = MX_DONE;
            MX_DONE: nstate = MX_IDLE;
            default: nstate = MX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MX_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            best      <= '0;
            best_idx  <= '0;
            found     <= 1'b0;
            idx_valid <= 1'b0;
            idx       <= '0;
        end else begin
            unique case (state)
                MX_IDLE: begin
                    if (start) begin
                        cnt   <= '0;
                        found <= 1'b0;
                    end
                end
                MX_SCAN: begin
                    if (take) begin
                        best     <= cand;
                        best_idx <= cnt;
                        found    <= 1'b1;
                    end
                    cnt <= cnt + 1'b1;
                end
                MX_DONE: begin
                    idx_valid <= found;
                    idx       <= best_idx;
                end
                default: ;
            endcase
        end
    end

    assign rsp_valid = (state == MX_DONE);
    assign rsp_data  = found ? best : ERR_NO_DATA;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r10_clean_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!is_err_code(rsp_data) || rsp_data == ERR_NO_DATA));
    a_r11_index_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (idx_valid == (rsp_data != ERR_NO_DATA || !$past(found))) || !$past(found));
endmodule

// File: rtl/thermal_alert_monitor.sv
module thermal_alert_monitor
    import tam_pkg::*;
#(
    parameter int NSOCK = 4,
    parameter int NDOM  = 2,
    localparam int NREG = NSOCK * NDOM,
    localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int SW   = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            res_valid,
    input  logic [IW-1:0]   res_index,
    input  logic [15:0]     res_value,
    input  logic [NREG-1:0] poll_en,
    input  logic            thr_we,
    input  logic [SW-1:0]   thr_sel,
    input  logic [15:0]     thr_wdata,
    output logic [15:0]     thr_rdata,
    input  logic            alert_mask,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    output logic            rsp_valid,
    output logic [15:0]     rsp_data,
    output logic            max_valid,
    output logic [15:0]     max_data,
    output logic            alert_n
);
    logic          over, active, clr, start, idx_valid;
    logic [IW-1:0] src, max_idx;

    assign clr   = cmd_valid && (cmd_code == CMD_CLR);
    assign start = cmd_valid && (cmd_code == CMD_RD_MAX);

    tam_thr_bank #(.NSOCK(NSOCK), .NDOM(NDOM), .IW(IW), .SW(SW)) u_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(thr_we), .sel(thr_sel),
        .wr_data(thr_wdata), .rd_data(thr_rdata),
        .res_valid(res_valid), .res_index(res_index), .res_value(res_value),
        .over(over)
    );

    tam_alert_fsm #(.IW(IW)) u_alert (
        .clk(clk), .rst_n(rst_n), .over(over), .idx(res_index),
        .mask(alert_mask), .clr(clr), .active(active), .src(src)
    );

    tam_max_scan #(.NREG(NREG), .IW(IW)) u_max (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_index(res_index),
        .res_value(res_value), .en(poll_en), .start(start),
        .rsp_valid(max_valid), .rsp_data(max_data),
        .idx_valid(idx_valid), .idx(max_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (cmd_valid && cmd_code == CMD_RD_ASRC) begin
                rsp_valid <= 1'b1;
                rsp_data  <= active ? {{(DW-IW){1'b0}}, src} : ERR_NO_ALERT;
            end else if (cmd_valid && cmd_code == CMD_RD_MAXIDX) begin
                rsp_valid <= 1'b1;
                rsp_data  <= idx_valid ? {{(DW-IW){1'b0}}, max_idx} : ERR_NO_DATA;
            end
        end
    end

    assign alert_n = !active;

    a_r8_error_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_n && res_valid && is_err_code(res_value)) |=> alert_n);
    a_r7_no_alert_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_RD_ASRC && alert_n) |=> (rsp_data == ERR_NO_ALERT));
    a_r2_alert_only_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_n && !res_valid) |=> alert_n);
endmodule

// File: tb/thermal_alert_monitor_test.sv
`timescale 1ns/1ps
module thermal_alert_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_index = '0;
    logic [15:0] res_value = '0;
    logic [7:0]  poll_en = '0;
    logic        thr_we = 1'b0;
    logic [1:0]  thr_sel = '0;
    logic [15:0] thr_wdata = '0;
    logic [15:0] thr_rdata;
    logic        alert_mask = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        max_valid;
    logic [15:0] max_data;
    logic        alert_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    thermal_alert_monitor uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_index(res_index),
        .res_value(res_value), .poll_en(poll_en), .thr_we(thr_we), .thr_sel(thr_sel),
        .thr_wdata(thr_wdata), .thr_rdata(thr_rdata), .alert_mask(alert_mask),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .max_valid(max_valid), .max_data(max_data),
        .alert_n(alert_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] i, input logic [15:0] v);
        @(negedge clk);
        res_valid = 1'b1; res_index = i; res_value = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic put_and_clear(input logic [2:0] i, input logic [15:0] v);
        @(negedge clk);
        res_valid = 1'b1; res_index = i; res_value = v;
        cmd_valid = 1'b1; cmd_code = 8'h15;
        @(negedge clk);
        res_valid = 1'b0; cmd_valid = 1'b0;
    endtask

    task automatic set_thr(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        thr_we = 1'b1; thr_sel = s; thr_wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic read_src(input string req, input logic [15:0] exp);
        cmd(8'h0B);
        chk({req, " rsp_valid"}, {15'd0, rsp_valid}, 16'd1);
        chk(req, rsp_data, exp);
    endtask

    task automatic read_maxidx(input string req, input logic [15:0] exp);
        cmd(8'h0A);
        chk({req, " rsp_valid"}, {15'd0, rsp_valid}, 16'd1);
        chk(req, rsp_data, exp);
    endtask

    task automatic read_max(input string req, input logic [15:0] exp);
        int waited = 0;
        cmd(8'h08);
        while (!max_valid && waited < 30) begin
            @(negedge clk);
            waited++;
        end
        chk({req, " max_valid"}, {15'd0, max_valid}, 16'd1);
        chk(req, max_data, exp);
        @(negedge clk);
        chk({req, " pulse ends"}, {15'd0, max_valid}, 16'd0);
    endtask

    task automatic t_reset;
        chk("R2 reset alert_n", {15'd0, alert_n}, 16'd1);
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            #0.1;
            chk("R1 threshold reset", thr_rdata, 16'h7FFF);
        end
        read_maxidx("R11 index before any scan", 16'h8104);
        read_src("R7 source with no alert", 16'h8103);
    endtask

    task automatic t_thresholds;
        set_thr(2'd0, 16'hFFC0);
        set_thr(2'd1, 16'h0640);
        set_thr(2'd2, 16'h1000);
        thr_sel = 2'd1; #0.1;
        chk("R1 threshold write", thr_rdata, 16'h0640);
        thr_sel = 2'd0; #0.1;
        chk("R1 negative threshold", thr_rdata, 16'hFFC0);
        thr_sel = 2'd3; #0.1;
        chk("R1 untouched threshold", thr_rdata, 16'h7FFF);
    endtask

    task automatic t_raise;
        put(3'd2, 16'h0640);
        chk("R2 equal no alert", {15'd0, alert_n}, 16'd1);
        put(3'd1, 16'hFF80);
        chk("R2 signed below no alert", {15'd0, alert_n}, 16'd1);
        put(3'd3, 16'h0641);
        chk("R2 above raises", {15'd0, alert_n}, 16'd0);
        read_src("R6 source index", 16'h0003);
    endtask

    task automatic t_sticky;
        put(3'd3, 16'h0000);
        chk("R3 drop keeps alert", {15'd0, alert_n}, 16'd0);
        put(3'd0, 16'h0000);
        read_src("R6 first violation kept", 16'h0003);
        chk("R3 still low", {15'd0, alert_n}, 16'd0);
    endtask

    task automatic t_clear;
        cmd(8'h15);
        chk("R4 clear releases", {15'd0, alert_n}, 16'd1);
        read_src("R7 source after clear", 16'h8103);
    endtask

    task automatic t_error_codes;
        set_thr(2'd3, 16'h8000);
        put(3'd6, 16'h8101);
        chk("R8 error code no alert", {15'd0, alert_n}, 16'd1);
        put(3'd7, 16'h81FF);
        chk("R8 top error code no alert", {15'd0, alert_n}, 16'd1);
        put(3'd6, 16'h8200);
        chk("R2 non-error above min threshold", {15'd0, alert_n}, 16'd0);
        read_src("R6 source socket3", 16'h0006);
        cmd(8'h15);
        set_thr(2'd3, 16'h7FFF);
    endtask

    task automatic t_same_cycle;
        put(3'd3, 16'h0700);
        chk("R2 raise before merge", {15'd0, alert_n}, 16'd0);
        put_and_clear(3'd4, 16'h1001);
        chk("R4 clear with violation stays", {15'd0, alert_n}, 16'd0);
        read_src("R4 source switches", 16'h0004);
        put_and_clear(3'd5, 16'h0FFF);
        chk("R4 clear with calm result", {15'd0, alert_n}, 16'd1);
    endtask

    task automatic t_mask;
        alert_mask = 1'b1;
        put(3'd3, 16'h0700);
        chk("R5 masked no alert", {15'd0, alert_n}, 16'd1);
        alert_mask = 1'b0;
        put(3'd2, 16'h0700);
        chk("R5 unmasked raises", {15'd0, alert_n}, 16'd0);
        alert_mask = 1'b1;
        put(3'd0, 16'hFFFF);
        repeat (3) @(negedge clk);
        chk("R5 mask keeps existing", {15'd0, alert_n}, 16'd0);
        put_and_clear(3'd3, 16'h0800);
        chk("R5 masked merge releases", {15'd0, alert_n}, 16'd1);
    endtask

    task automatic t_max;
        alert_mask = 1'b1;
        poll_en = 8'h00;
        read_max("R10 nothing enabled", 16'h8104);
        read_maxidx("R11 index after empty scan", 16'h8104);
        put(3'd0, 16'h0100);
        put(3'd1, 16'h0500);
        put(3'd2, 16'h0500);
        put(3'd3, 16'hFF00);
        put(3'd4, 16'h8100);
        put(3'd5, 16'h7000);
        put(3'd6, 16'h8200);
        poll_en = 8'b0000_1111;
        read_max("R9 maximum of low group", 16'h0500);
        read_maxidx("R9 tie picks lower index", 16'h0001);
        poll_en = 8'b1111_0000;
        read_max("R9 skips error code", 16'h7000);
        read_maxidx("R11 index of maximum", 16'h0005);
        poll_en = 8'b0101_1000;
        read_max("R9 signed compare", 16'hFF00);
        read_maxidx("R11 signed index", 16'h0003);
        poll_en = 8'b0001_0000;
        read_max("R10 only error enabled", 16'h8104);
        read_maxidx("R11 index after failed scan", 16'h8104);
        alert_mask = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thresholds();
        t_raise();
        t_sticky();
        t_clear();
        t_error_codes();
        t_same_cycle();
        t_mask();
        t_max();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule